// File: doc/BRIEF.md
# Hierarchical Capability Chain Evaluator

This block turns a segmented virtual address into a physical word address. It walks up a tree of processes. The walk starts in the process whose base address comes with the request. The block selects one of that process's capability segments, reads the chosen capability and follows it to an entry in the process's resource list. That entry names a capability held by the parent process, which leads to the parent's resource list, and so on. The walk stops when it reaches a process whose resource list is the master list, where an entry carries the physical segment address.

Every capability and every list entry on the way refines the window. Each one may only shrink the window that came from below, and its base is added on. Access rights are ANDed at every step. At the end the word offset is checked against the final size, and the requested rights are checked against the rights that survived the walk.

Words are fetched one at a time through a simple read port that allows one read in flight and any latency. A result is a one-cycle pulse carrying either a physical address with its granted rights or a fault code.

Top module: `cap_chain_walker`

## Requirements
- R1: The virtual address holds the capability segment number in bits 31:28, the capability index in bits 23:16 and the word offset in bits 15:0. Word `s` of a process base (s = 0..15) holds a valid flag in bit 31 and an 8-bit segment slot in bits 7:0. A cleared valid flag, in the current process or in any parent reached by the walk, ends the walk with fault code 1.
- R2: A capability occupies two words at process base + 64 + 2·{slot, index}. The first word holds a type in bits 31:30 (01 data segment, 10 capability segment, 00 and 11 give fault code 2), rights {R,W,E} in bits 26:24 and a resource-list index in bits 23:16. The second word holds a base in bits 31:16 and a size in bits 15:0.
- R3: Word 16 of a process base holds a master flag in bit 31 and the resource-list address in bits 19:0. Word 17 holds the parent's process base in bits 19:0. List entry `i` occupies two words at list address + 2·i and uses the same base/size second word. A non-master entry holds the parent segment number in bits 31:28, the parent capability index in bits 23:16 and rights in bits 26:24. A master entry holds rights in bits 26:24 and the physical segment address in bits 19:0.
- R4: The granted rights are the AND of the rights of every capability and entry visited. A capability of type capability segment contributes no execute right.
- R5: Each refining descriptor requires that the accumulated base plus the accumulated size is no larger than the descriptor's own size (equality passes). Otherwise the walk ends with fault code 3. On success the descriptor's base is added to the accumulated base.
- R6: On success the physical address is the master entry's address plus the accumulated base plus the word offset, and the size is that of the first capability.
- R7: At the master entry, after the range check, an offset that is greater than or equal to the size gives fault code 5.
- R8: After the offset check, a requested right that is missing from the granted rights gives fault code 6.
- R9: At most MAX_LEVELS processes (default 4) are visited. A non-master process that is the MAX_LEVELS-th visited gives fault code 4. A master reached as the MAX_LEVELS-th process succeeds.
- R10: `done` is a one-cycle pulse. On a fault, `phys_addr` and `granted` are zero. `req_ready` is high only when no walk is in progress, and no read is issued then. At most one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when req_ready is high) |
| req_ready | output | 1 | Walker idle |
| req_pbase | input | AW | Process base of the current process |
| req_vaddr | input | 32 | Virtual address |
| req_rights | input | 3 | Requested rights {R,W,E} |
| mem_rd | output | 1 | Read strobe, one cycle |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result pulse |
| fault | output | 3 | 0 on success, otherwise the fault code |
| phys_addr | output | AW | Physical word address |
| granted | output | 3 | Rights left after the walk |

## Verification
The hardest situations to reach are those that only appear deep in the chain: a list entry that points to a cleared slot in a grandparent, a window that fits at every level except the master entry, and the depth limit itself. The bench builds a memory image with a three-level tree, a four-level branch and a process that names itself as its parent. The self-parented process lets a single request climb until the depth limit trips. Rights are narrowed at different levels on different paths, so the final AND depends on more than one contributor.

// File: rtl/cap_chain_walker.sv
module cap_chain_walker #(
  parameter int AW         = 20,
  parameter int MAX_LEVELS = 4,
  parameter int CAP_AREA   = 64,
  parameter int CTRL_WORD  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_pbase,
  input  logic [31:0]   req_vaddr,
  input  logic [2:0]    req_rights,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic [2:0]    fault,
  output logic [AW-1:0] phys_addr,
  output logic [2:0]    granted
);
  localparam int LW = $clog2(MAX_LEVELS + 1);
  localparam logic [LW-1:0] LAST = LW'(MAX_LEVELS - 1);
  localparam logic [2:0] F_OK = 3'd0, F_SEG = 3'd1, F_TYPE = 3'd2, F_RANGE = 3'd3,
                         F_DEPTH = 3'd4, F_OFFSET = 3'd5, F_RIGHTS = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_SEG, S_CAPA, S_CAPB, S_CTRL, S_PAR, S_PRLA, S_PRLB} st_t;

  st_t           st;
  logic          pend, first, master;
  logic [AW-1:0] pb, prlb, parpb, acc_b, phys_q;
  logic [3:0]    seg;
  logic [7:0]    idx, slot;
  logic [15:0]   off, acc_s;
  logic [2:0]    rq, acc_r, fault_q, granted_q;
  logic [31:0]   wa;
  logic [LW-1:0] lvl;
  logic          done_q;

  assign req_ready = (st == S_IDLE);
  assign mem_rd    = (st != S_IDLE) && !pend;
  assign done      = done_q;
  assign fault     = fault_q;
  assign phys_addr = phys_q;
  assign granted   = granted_q;

  wire [15:0]   d_base = mem_rdata[31:16];
  wire [15:0]   d_size = mem_rdata[15:0];
  wire [AW:0]   reach  = {1'b0, acc_b} + {{(AW-15){1'b0}}, acc_s};
  wire          overrun = !first && (reach > {{(AW-15){1'b0}}, d_size});
  wire [AW-1:0] nb = first ? {{(AW-16){1'b0}}, d_base} : acc_b + {{(AW-16){1'b0}}, d_base};
  wire [15:0]   ns = first ? d_size : acc_s;
  wire [2:0]    cap_mask = wa[26:24] & ((wa[31:30] == 2'b10) ? 3'b110 : 3'b111);
  wire [2:0]    nr_cap = first ? cap_mask : (acc_r & cap_mask);
  wire [2:0]    nr_prl = acc_r & wa[26:24];
  wire [AW-1:0] cap_at = pb + AW'(CAP_AREA) + {{(AW-17){1'b0}}, slot, idx, 1'b0};
  wire [AW-1:0] prl_at = prlb + {{(AW-9){1'b0}}, idx, 1'b0};
  wire [AW-1:0] phys_ok = wa[AW-1:0] + nb + {{(AW-16){1'b0}}, off};

  always_comb begin
    case (st)
      S_SEG:   mem_addr = pb + {{(AW-4){1'b0}}, seg};
      S_CAPA:  mem_addr = cap_at;
      S_CAPB:  mem_addr = cap_at + AW'(1);
      S_CTRL:  mem_addr = pb + AW'(CTRL_WORD);
      S_PAR:   mem_addr = pb + AW'(CTRL_WORD + 1);
      S_PRLA:  mem_addr = prl_at;
      S_PRLB:  mem_addr = prl_at + AW'(1);
      default: mem_addr = '0;
    endcase
  end

  logic [2:0] step_fault;
  always_comb begin
    step_fault = F_OK;
    case (st)
      S_SEG:  if (!mem_rdata[31]) step_fault = F_SEG;
      S_CAPA: if (mem_rdata[31:30] == 2'b00 || mem_rdata[31:30] == 2'b11) step_fault = F_TYPE;
      S_CAPB: if (overrun) step_fault = F_RANGE;
      S_CTRL: if (!mem_rdata[31] && lvl == LAST) step_fault = F_DEPTH;
      S_PRLB: begin
        if (overrun) step_fault = F_RANGE;
        else if (master && off >= ns) step_fault = F_OFFSET;
        else if (master && (rq & ~nr_prl) != 3'b000) step_fault = F_RIGHTS;
      end
      default: step_fault = F_OK;
    endcase
  end
  wire finish = (step_fault != F_OK) || (st == S_PRLB && master);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; first <= 1'b0; master <= 1'b0;
      pb <= '0; prlb <= '0; parpb <= '0; acc_b <= '0; phys_q <= '0;
      seg <= '0; idx <= '0; slot <= '0; off <= '0; acc_s <= '0;
      rq <= '0; acc_r <= '0; fault_q <= '0; granted_q <= '0; wa <= '0;
      lvl <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          pb    <= req_pbase;
          seg   <= req_vaddr[31:28];
          idx   <= req_vaddr[23:16];
          off   <= req_vaddr[15:0];
          rq    <= req_rights;
          first <= 1'b1;
          lvl   <= '0;
          st    <= S_SEG;
        end
      end else if (!pend) begin
        pend <= 1'b1;
      end else if (mem_rvalid) begin
        pend <= 1'b0;
        if (finish) begin
          done_q    <= 1'b1;
          fault_q   <= step_fault;
          phys_q    <= (step_fault == F_OK) ? phys_ok : '0;
          granted_q <= (step_fault == F_OK) ? nr_prl : 3'b000;
          st        <= S_IDLE;
        end else begin
          case (st)
            S_SEG:  begin slot <= mem_rdata[7:0]; st <= S_CAPA; end
            S_CAPA: begin wa <= mem_rdata; st <= S_CAPB; end
            S_CAPB: begin
              acc_b <= nb; acc_s <= ns; acc_r <= nr_cap;
              idx <= wa[23:16]; first <= 1'b0; st <= S_CTRL;
            end
            S_CTRL: begin
              master <= mem_rdata[31];
              prlb   <= mem_rdata[AW-1:0];
              st     <= mem_rdata[31] ? S_PRLA : S_PAR;
            end
            S_PAR:  begin parpb <= mem_rdata[AW-1:0]; st <= S_PRLA; end
            S_PRLA: begin wa <= mem_rdata; st <= S_PRLB; end
            S_PRLB: begin
              acc_b <= nb; acc_r <= nr_prl;
              pb <= parpb; seg <= wa[31:28]; idx <= wa[23:16];
              lvl <= lvl + LW'(1);
              st <= S_SEG;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != F_OK) |-> (phys_addr == '0 && granted == 3'b000));
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_rd);
  p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd);
  p_rights_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == F_OK) |-> ((rq & ~granted) == 3'b000));
  p_offset_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == F_OK) |-> (off < acc_s));
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n) lvl <= LAST);
endmodule

// File: tb/cap_chain_walker_bench.sv
module cap_chain_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, mem_rd, mem_rvalid = 1'b0, done;
  logic [19:0] req_pbase = '0, mem_addr, phys_addr;
  logic [31:0] req_vaddr = '0, mem_rdata = '0;
  logic [2:0]  req_rights = '0, fault, granted;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_chain_walker u_cap_chain_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pbase(req_pbase), .req_vaddr(req_vaddr), .req_rights(req_rights),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .phys_addr(phys_addr), .granted(granted));

  logic [31:0] mem [int unsigned];
  logic [19:0] rd_addr = '0;
  int          lat = 0;
  logic        busy = 1'b0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd) begin
      rd_addr <= mem_addr; lat <= 1 + int'(mem_addr % 3); busy <= 1'b1;
    end else if (busy) begin
      if (lat == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(int'(rd_addr)) ? mem[int'(rd_addr)] : 32'h0;
        busy <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  function automatic logic [31:0] capw(logic [1:0] t, logic [2:0] r, logic [7:0] i);
    return {t, 3'b000, r, i, 16'h0};
  endfunction
  function automatic logic [31:0] entw(logic [3:0] s, logic [2:0] r, logic [7:0] i);
    return {s, 1'b0, r, i, 16'h0};
  endfunction
  function automatic logic [31:0] mstw(logic [2:0] r, logic [19:0] a);
    return {5'b0, r, 4'b0, a};
  endfunction
  task automatic wr(logic [19:0] a, logic [31:0] v); mem[int'(a)] = v; endtask
  task automatic put_cap(logic [19:0] pb, logic [7:0] sl, logic [7:0] i, logic [31:0] w0,
                         logic [15:0] b, logic [15:0] s);
    logic [19:0] a = pb + 20'd64 + {3'b0, sl, i, 1'b0};
    wr(a, w0); wr(a + 20'd1, {b, s});
  endtask
  task automatic put_ent(logic [19:0] lb, logic [7:0] i, logic [31:0] w0,
                         logic [15:0] b, logic [15:0] s);
    wr(lb + {11'b0, i, 1'b0}, w0); wr(lb + {11'b0, i, 1'b0} + 20'd1, {b, s});
  endtask

  typedef struct packed {
    logic [19:0] pb; logic [31:0] va; logic [2:0] rq;
    logic [2:0] f; logic [19:0] pa; logic [2:0] gr; logic [3:0] req;
  } vec_t;
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{20'h30000, 32'h10070005, 3'b100, 3'd0, 20'h80181, 3'b110, 4'd6},  // R6 R5 three levels
    '{20'h30000, 32'h1007001F, 3'b110, 3'd0, 20'h8019B, 3'b110, 4'd7},  // R7 last word
    '{20'h30000, 32'h10070020, 3'b100, 3'd5, 20'h00000, 3'b000, 4'd7},  // R7 one past
    '{20'h30000, 32'h10070000, 3'b001, 3'd6, 20'h00000, 3'b000, 4'd8},  // R8
    '{20'h30000, 32'h20070000, 3'b100, 3'd1, 20'h00000, 3'b000, 4'd1},  // R1 current slot
    '{20'h30000, 32'h10090000, 3'b100, 3'd2, 20'h00000, 3'b000, 4'd2},  // R2 null type
    '{20'h30000, 32'h10080003, 3'b110, 3'd0, 20'h80173, 3'b110, 4'd4},  // R4 cap-segment type
    '{20'h30000, 32'h10080000, 3'b001, 3'd6, 20'h00000, 3'b000, 4'd4},  // R4 no execute
    '{20'h30000, 32'h100A0000, 3'b000, 3'd3, 20'h00000, 3'b000, 4'd5},  // R5 at first entry
    '{20'h30000, 32'h100B004F, 3'b000, 3'd0, 20'h9005F, 3'b000, 4'd4},  // R4 AND to empty
    '{20'h30000, 32'h100B0000, 3'b010, 3'd6, 20'h00000, 3'b000, 4'd8},  // R8
    '{20'h30000, 32'h100C0000, 3'b000, 3'd1, 20'h00000, 3'b000, 4'd1},  // R1 grandparent slot
    '{20'h30000, 32'h100D0000, 3'b000, 3'd3, 20'h00000, 3'b000, 4'd5},  // R5 at master entry
    '{20'h50000, 32'h00000002, 3'b100, 3'd0, 20'h8017E, 3'b110, 4'd9},  // R9 four levels ok
    '{20'h40000, 32'h00000000, 3'b000, 3'd4, 20'h00000, 3'b000, 4'd9}   // R9 too deep
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic walk(vec_t v, int k);
    int waitc = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_pbase = v.pb; req_vaddr = v.va; req_rights = v.rq; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && waitc < 2000) begin @(negedge clk); waitc++; end
    n_chk++;
    if (!done || fault != v.f || phys_addr != v.pa || granted != v.gr) begin
      n_bad++;
      $display("FAIL R%0d vector %0d: got done=%b fault=%0d phys=%h rights=%b, expected fault=%0d phys=%h rights=%b",
               v.req, k, done, fault, phys_addr, granted, v.f, v.pa, v.gr);
    end
    if (done) begin
      @(negedge clk);
      n_chk++;
      if (done) begin
        n_bad++;
        $display("FAIL R10 vector %0d: done stayed high, got 1 expected 0", k);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    // master process
    wr(20'h10010, {1'b1, 11'b0, 20'h18000});
    wr(20'h10003, 32'h80000001);
    put_ent(20'h18000, 8'h04, mstw(3'b111, 20'h80000), 16'h0010, 16'h0800);
    put_ent(20'h18000, 8'h09, mstw(3'b101, 20'h90000), 16'h0000, 16'h0100);
    put_cap(20'h10000, 8'h01, 8'h20, capw(2'b01, 3'b111, 8'h04), 16'h0100, 16'h0400);
    put_cap(20'h10000, 8'h01, 8'h21, capw(2'b01, 3'b110, 8'h09), 16'h0000, 16'h0080);
    put_cap(20'h10000, 8'h01, 8'h22, capw(2'b01, 3'b111, 8'h04), 16'h07F8, 16'h0200);
    // middle process
    wr(20'h20010, {12'b0, 20'h28000}); wr(20'h20011, 32'h00010000);
    wr(20'h20001, 32'h80000003);
    put_ent(20'h28000, 8'h05, entw(4'd3, 3'b111, 8'h20), 16'h0040, 16'h0200);
    put_ent(20'h28000, 8'h06, entw(4'd3, 3'b011, 8'h21), 16'h0010, 16'h0060);
    put_ent(20'h28000, 8'h07, entw(4'd6, 3'b111, 8'h20), 16'h0000, 16'h0010);
    put_ent(20'h28000, 8'h08, entw(4'd3, 3'b111, 8'h22), 16'h0000, 16'h0100);
    put_cap(20'h20000, 8'h03, 8'h30, capw(2'b01, 3'b111, 8'h05), 16'h0020, 16'h0100);
    put_cap(20'h20000, 8'h03, 8'h31, capw(2'b01, 3'b111, 8'h06), 16'h0000, 16'h0060);
    put_cap(20'h20000, 8'h03, 8'h32, capw(2'b01, 3'b111, 8'h07), 16'h0000, 16'h0020);
    put_cap(20'h20000, 8'h03, 8'h33, capw(2'b01, 3'b111, 8'h08), 16'h0000, 16'h0020);
    // current process
    wr(20'h30010, {12'b0, 20'h38000}); wr(20'h30011, 32'h00020000);
    wr(20'h30001, 32'h80000002);
    put_cap(20'h30000, 8'h02, 8'h07, capw(2'b01, 3'b111, 8'h11), 16'h0008, 16'h0020);
    put_cap(20'h30000, 8'h02, 8'h08, capw(2'b10, 3'b111, 8'h12), 16'h0000, 16'h0010);
    put_cap(20'h30000, 8'h02, 8'h09, capw(2'b00, 3'b111, 8'h11), 16'h0000, 16'h0010);
    put_cap(20'h30000, 8'h02, 8'h0A, capw(2'b01, 3'b111, 8'h13), 16'h0000, 16'h0100);
    put_cap(20'h30000, 8'h02, 8'h0B, capw(2'b01, 3'b111, 8'h14), 16'h0000, 16'h0050);
    put_cap(20'h30000, 8'h02, 8'h0C, capw(2'b01, 3'b111, 8'h15), 16'h0000, 16'h0010);
    put_cap(20'h30000, 8'h02, 8'h0D, capw(2'b01, 3'b111, 8'h16), 16'h0000, 16'h0010);
    put_ent(20'h38000, 8'h11, entw(4'd1, 3'b110, 8'h30), 16'h0004, 16'h0040);
    put_ent(20'h38000, 8'h12, entw(4'd1, 3'b111, 8'h30), 16'h0000, 16'h0040);
    put_ent(20'h38000, 8'h13, entw(4'd1, 3'b111, 8'h30), 16'h0000, 16'h0040);
    put_ent(20'h38000, 8'h14, entw(4'd1, 3'b111, 8'h31), 16'h0000, 16'h0060);
    put_ent(20'h38000, 8'h15, entw(4'd1, 3'b111, 8'h32), 16'h0000, 16'h0020);
    put_ent(20'h38000, 8'h16, entw(4'd1, 3'b111, 8'h33), 16'h0000, 16'h0020);
    // fourth-level child of the current process
    wr(20'h50010, {12'b0, 20'h58000}); wr(20'h50011, 32'h00030000);
    wr(20'h50000, 32'h80000000);
    put_cap(20'h50000, 8'h00, 8'h00, capw(2'b01, 3'b111, 8'h01), 16'h0000, 16'h0010);
    put_ent(20'h58000, 8'h01, entw(4'd1, 3'b111, 8'h07), 16'h0000, 16'h0010);
    // self-parented process
    wr(20'h40010, {12'b0, 20'h48000}); wr(20'h40011, 32'h00040000);
    wr(20'h40000, 32'h80000000);
    put_cap(20'h40000, 8'h00, 8'h00, capw(2'b01, 3'b111, 8'h00), 16'h0000, 16'h0010);
    put_ent(20'h48000, 8'h00, entw(4'd0, 3'b111, 8'h00), 16'h0000, 16'h0010);

    repeat (3) @(negedge clk);
    n_chk++;  // R10 reset state
    if (!req_ready || done || mem_rd || fault != 3'd0 || phys_addr != 20'h0) begin
      n_bad++;
      $display("FAIL R10 reset: got ready=%b done=%b rd=%b fault=%0d phys=%h, expected 1 0 0 0 00000",
               req_ready, done, mem_rd, fault, phys_addr);
    end
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) walk(VECS[k], k);
    // R3 the same walk twice in a row gives the same result (no state carried over)
    walk(VECS[0], 0);
    // R10 idle again after the last walk
    repeat (4) @(negedge clk);
    n_chk++;
    if (!req_ready || mem_rd) begin
      n_bad++;
      $display("FAIL R10 idle: got ready=%b rd=%b, expected 1 0", req_ready, mem_rd);
    end
    summary();
    $finish;
  end
endmodule